// File: doc/BRIEF.md
# Sequential Unsigned Multiply/Divide Unit

This block is the multicycle arithmetic engine beside the ALU of an 8-bit processor core. On a one-cycle start strobe it captures its operands and runs either an unsigned 8x8 multiply, which yields a 16-bit product, or an unsigned 16/8 divide, which yields an 8-bit quotient and an 8-bit remainder. Both use a radix-2 loop that retires one bit per clock, so the run time never depends on the operand values.

The 16-bit accumulator operand carries the dividend for a divide. For a multiply it carries the multiplier in its low byte. The 8-bit operand is the multiplicand or the divisor. The divide packs its answer into a single 16-bit word that takes the place of the dividend: the quotient sits in the low byte and the remainder in the high byte. A zero divisor, or a quotient too large for 8 bits, is reported on the V flag, and the dividend is then handed back unchanged. The result and flags are registered. They change only on the cycle where `done_o` pulses, and they hold until the next completion.

The reset input is asynchronous and active low. Its release is synchronised internally over two clock edges.

Top module: `seqmd_unit`

## Requirements
- R1: With `op_div_i`=0, the result is the unsigned product of `acc_i[7:0]` and `opnd_i`. `acc_i[15:8]` has no effect on the product.
- R2: A multiply accepted at clock edge E raises `done_o` after edge E+8.
- R3: With `op_div_i`=1 and a valid divide, `result_o[7:0]` is floor(`acc_i`/`opnd_i`) and `result_o[15:8]` is the remainder.
- R4: A divide accepted at clock edge E raises `done_o` after edge E+9. This holds for overflow and divide-by-zero cases as well.
- R5: A divide with `opnd_i`=0 completes with V=1, N=0 and Z=0, and the result equals the dividend.
- R6: A divide with `acc_i[15:8]` >= `opnd_i` (quotient wider than 8 bits) completes with V=1, N=0 and Z=0, and the result equals the dividend.
- R7: `busy_o` is 1 from the cycle after a start is accepted until the cycle in which `done_o` is 1. `done_o` is high for exactly one cycle, and `busy_o` is 0 in that cycle.
- R8: A start strobe while `busy_o`=1 is ignored. The running operation finishes with its own operands and timing, and no extra completion follows.
- R9: Z=1 when a multiply's 16-bit product is zero, or when a valid divide's quotient is zero. Otherwise Z=0.
- R10: For a multiply or a valid divide, N equals `result_o[15]` and V=0.
- R11: While reset is held and after it is released, `busy_o`, `done_o`, `result_o` and all flags are 0 until the first completion.
- R12: `result_o` and the flags keep their values in every cycle in which `done_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe, taken when not busy |
| op_div_i | input | 1 | 0 = multiply, 1 = divide |
| acc_i | input | 16 | Dividend, or multiplier in bits 7:0 |
| opnd_i | input | 8 | Multiplicand or divisor |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 16 | Product, or {remainder, quotient}, or the unchanged dividend on V |
| flag_v_o | output | 1 | Divide overflow or divide by zero |
| flag_n_o | output | 1 | Result bit 15 |
| flag_z_o | output | 1 | Zero product or zero quotient |

## Verification
A fault in the step counter appears at once as a wrong latency: `done_o` arrives early or late relative to the 8- or 9-edge schedule, which the bench measures for every operation. A corrupted partial remainder or partial product has no visible effect until the completion cycle, where it shows as a miscompare on `result_o` or on the Z and N flags. An overflow decision that goes the wrong way shows at the same completion as a V flag that differs from the expected value, together with a result that either was or was not the unchanged dividend. Embedded properties catch a remainder that escapes its bound, or a frozen datapath that moves, on the very cycle it happens.

// File: rtl/seqmd_pkg.sv
package seqmd_pkg;

  typedef enum logic {
    MD_MUL = 1'b0,
    MD_DIV = 1'b1
  } md_op_e;

  typedef struct packed {
    logic v;
    logic n;
    logic z;
  } md_flags_t;

endpackage

// File: rtl/seqmd_rst_sync.sv
module seqmd_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync_o
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_sync_o = sync_q[STAGES-1];

endmodule

// File: rtl/seqmd_seq.sv
module seqmd_seq #(
  parameter int W = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic op_div_i,
  output logic load_o,
  output logic step_o,
  output logic fin_o,
  output logic busy_o,
  output logic done_o
);

  localparam int MUL_LAT = W;
  localparam int DIV_LAT = W + 1;
  localparam int CW      = $clog2(DIV_LAT + 1);
  localparam logic [CW-1:0] MUL_CNT = CW'(MUL_LAT);
  localparam logic [CW-1:0] DIV_CNT = CW'(DIV_LAT);
  localparam logic [CW-1:0] ONE_CNT = CW'(1);

  logic          busy_q, busy_d;
  logic          done_q, done_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          load, last;

  assign load = start_i && !busy_q;
  assign last = busy_q && (cnt_q == ONE_CNT);

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    done_d = last;
    if (load) begin
      busy_d = 1'b1;
      cnt_d  = op_div_i ? DIV_CNT : MUL_CNT;
    end else if (busy_q) begin
      cnt_d = cnt_q - ONE_CNT;
      if (last) begin
        busy_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      cnt_q  <= cnt_d;
    end
  end

  assign load_o = load;
  assign step_o = busy_q;
  assign fin_o  = last;
  assign busy_o = busy_q;
  assign done_o = done_q;

  // R8: an active count walks down by one each cycle, whatever start does
  p_cnt_walk_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && cnt_q > ONE_CNT) |=> (busy_q && cnt_q == $past(cnt_q) - ONE_CNT));

  // R2 / R4: a fresh operation starts with one of the two fixed latencies
  p_lat_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> (cnt_q == MUL_CNT || cnt_q == DIV_CNT));

endmodule

// File: rtl/seqmd_mul.sv
module seqmd_mul #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic         step_i,
  input  logic [W-1:0] mcand_i,
  input  logic [W-1:0] mplier_i,
  output logic [2*W-1:0] prod_next_o
);

  logic [W-1:0] mcand_q, mcand_d;
  logic [W-1:0] hi_q, hi_d;
  logic [W-1:0] lo_q, lo_d;
  logic [W:0]   sum;
  logic         en;

  assign sum = {1'b0, hi_q} + (lo_q[0] ? {1'b0, mcand_q} : '0);
  assign en  = load_i || step_i;

  always_comb begin
    mcand_d = mcand_q;
    hi_d    = hi_q;
    lo_d    = lo_q;
    if (load_i) begin
      mcand_d = mcand_i;
      hi_d    = '0;
      lo_d    = mplier_i;
    end else if (step_i) begin
      hi_d = sum[W:1];
      lo_d = {sum[0], lo_q[W-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mcand_q <= '0;
      hi_q    <= '0;
      lo_q    <= '0;
    end else if (en) begin
      mcand_q <= mcand_d;
      hi_q    <= hi_d;
      lo_q    <= lo_d;
    end
  end

  assign prod_next_o = {hi_d, lo_d};

  // R1: the multiplicand stays put while partial products accumulate
  p_mcand_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !load_i) |=> $stable(mcand_q));

endmodule

// File: rtl/seqmd_div.sv
module seqmd_div #(
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load_i,
  input  logic           step_i,
  input  logic [2*W-1:0] dvnd_i,
  input  logic [W-1:0]   dvsr_i,
  output logic [2*W-1:0] res_next_o,
  output logic           ovf_next_o
);

  logic [W-1:0] dvsr_q, dvsr_d;
  logic [W-1:0] rem_q, rem_d;
  logic [W-1:0] quo_q, quo_d;
  logic         chk_q, chk_d;
  logic         ovf_q, ovf_d;
  logic [W:0]   shifted, diff;
  logic         ge;
  logic         en;

  assign shifted = {rem_q, quo_q[W-1]};
  assign diff    = shifted - {1'b0, dvsr_q};
  assign ge      = shifted >= {1'b0, dvsr_q};
  assign en      = load_i || step_i;

  always_comb begin
    dvsr_d = dvsr_q;
    rem_d  = rem_q;
    quo_d  = quo_q;
    chk_d  = chk_q;
    ovf_d  = ovf_q;
    if (load_i) begin
      dvsr_d = dvsr_i;
      rem_d  = dvnd_i[2*W-1:W];
      quo_d  = dvnd_i[W-1:0];
      chk_d  = 1'b1;
      ovf_d  = 1'b0;
    end else if (step_i) begin
      if (chk_q) begin
        chk_d = 1'b0;
        ovf_d = (dvsr_q == '0) || (rem_q >= dvsr_q);
      end else if (!ovf_q) begin
        rem_d = ge ? diff[W-1:0] : shifted[W-1:0];
        quo_d = {quo_q[W-2:0], ge};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dvsr_q <= '0;
      rem_q  <= '0;
      quo_q  <= '0;
      chk_q  <= 1'b0;
      ovf_q  <= 1'b0;
    end else if (en) begin
      dvsr_q <= dvsr_d;
      rem_q  <= rem_d;
      quo_q  <= quo_d;
      chk_q  <= chk_d;
      ovf_q  <= ovf_d;
    end
  end

  assign res_next_o = {rem_d, quo_d};
  assign ovf_next_o = ovf_d;

  // R5 / R6: once overflow is decided, the dividend is frozen
  p_ovf_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && step_i && !load_i) |=> ($stable(rem_q) && $stable(quo_q)));

  // R3: after the range check, the partial remainder stays below the divisor
  p_rem_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!chk_q && !ovf_q && dvsr_q != '0) |-> (rem_q < dvsr_q));

endmodule

// File: rtl/seqmd_unit.sv
module seqmd_unit #(
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start_i,
  input  logic           op_div_i,
  input  logic [2*W-1:0] acc_i,
  input  logic [W-1:0]   opnd_i,
  output logic           busy_o,
  output logic           done_o,
  output logic [2*W-1:0] result_o,
  output logic           flag_v_o,
  output logic           flag_n_o,
  output logic           flag_z_o
);

  import seqmd_pkg::*;

  localparam int RW = 2 * W;

  logic            rst_ns;
  logic            load, step, fin;
  md_op_e          op_q, op_d;
  logic [RW-1:0]   mul_next, div_next;
  logic            div_ovf;
  logic [RW-1:0]   res_q, res_d;
  md_flags_t       flg_q, flg_d;

  seqmd_rst_sync #(.STAGES(2)) u_rst (
    .clk          (clk),
    .rst_n        (rst_n),
    .rst_n_sync_o (rst_ns)
  );

  seqmd_seq #(.W(W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_ns),
    .start_i  (start_i),
    .op_div_i (op_div_i),
    .load_o   (load),
    .step_o   (step),
    .fin_o    (fin),
    .busy_o   (busy_o),
    .done_o   (done_o)
  );

  seqmd_mul #(.W(W)) u_mul (
    .clk         (clk),
    .rst_n       (rst_ns),
    .load_i      (load && !op_div_i),
    .step_i      (step && op_q == MD_MUL),
    .mcand_i     (opnd_i),
    .mplier_i    (acc_i[W-1:0]),
    .prod_next_o (mul_next)
  );

  seqmd_div #(.W(W)) u_div (
    .clk        (clk),
    .rst_n      (rst_ns),
    .load_i     (load && op_div_i),
    .step_i     (step && op_q == MD_DIV),
    .dvnd_i     (acc_i),
    .dvsr_i     (opnd_i),
    .res_next_o (div_next),
    .ovf_next_o (div_ovf)
  );

  always_comb begin
    op_d  = load ? md_op_e'(op_div_i) : op_q;
    res_d = res_q;
    flg_d = flg_q;
    if (fin) begin
      if (op_q == MD_DIV) begin
        res_d   = div_next;
        flg_d.v = div_ovf;
        flg_d.n = !div_ovf && div_next[RW-1];
        flg_d.z = !div_ovf && (div_next[W-1:0] == '0);
      end else begin
        res_d   = mul_next;
        flg_d.v = 1'b0;
        flg_d.n = mul_next[RW-1];
        flg_d.z = (mul_next == '0);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      op_q <= MD_MUL;
    end else if (load) begin
      op_q <= op_d;
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      res_q <= '0;
      flg_q <= '0;
    end else if (fin) begin
      res_q <= res_d;
      flg_q <= flg_d;
    end
  end

  assign result_o = res_q;
  assign flag_v_o = flg_q.v;
  assign flag_n_o = flg_q.n;
  assign flag_z_o = flg_q.z;

  // R7: completion is a single-cycle pulse
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_ns)
    done_o |=> !done_o);

  // R7: busy is already low when done is seen
  p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_ns)
    done_o |-> !busy_o);

  // R12: outputs move only on a completion
  p_hold_r12: assert property (@(posedge clk) disable iff (!rst_ns)
    !done_o |-> ($stable(result_o) && $stable(flag_v_o) && $stable(flag_n_o) && $stable(flag_z_o)));

  // R5 / R6: an overflow completion reports neither N nor Z
  p_ovf_flags_r5: assert property (@(posedge clk) disable iff (!rst_ns)
    (done_o && flag_v_o) |-> (!flag_n_o && !flag_z_o));

endmodule

// File: tb/seqmd_unit_tb.sv
module seqmd_unit_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 14;

  logic        clk;
  logic        rst_n;
  logic        start_i;
  logic        op_div_i;
  logic [15:0] acc_i;
  logic [7:0]  opnd_i;
  logic        busy_o, done_o;
  logic [15:0] result_o;
  logic        flag_v_o, flag_n_o, flag_z_o;

  int n_chk;
  int n_bad;

  seqmd_unit #(.W(8)) dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .op_div_i (op_div_i),
    .acc_i    (acc_i),
    .opnd_i   (opnd_i),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .result_o (result_o),
    .flag_v_o (flag_v_o),
    .flag_n_o (flag_n_o),
    .flag_z_o (flag_z_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // stimulus table: {op, acc, opnd}
  localparam logic [24:0] VEC [NVEC] = '{
    {1'b0, 16'h00FF, 8'hFF},
    {1'b0, 16'h0000, 8'h37},
    {1'b0, 16'h0012, 8'h00},
    {1'b0, 16'h0080, 8'h02},
    {1'b0, 16'h000D, 8'h0B},
    {1'b0, 16'hAB05, 8'h03},
    {1'b1, 16'h1234, 8'h56},
    {1'b1, 16'h0005, 8'h07},
    {1'b1, 16'hFE01, 8'hFF},
    {1'b1, 16'h00FF, 8'h01},
    {1'b1, 16'h0304, 8'h00},
    {1'b1, 16'h2000, 8'h20},
    {1'b1, 16'hC8FF, 8'hC9},
    {1'b1, 16'h7FFF, 8'hFF}
  };

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [18:0] model(input logic op, input logic [15:0] a,
                                        input logic [7:0] b);
    logic [15:0] r;
    logic v, n, z;
    if (!op) begin
      r = 16'(a[7:0]) * 16'(b);
      v = 1'b0; n = r[15]; z = (r == 16'h0);
    end else if (b == 8'h00 || a[15:8] >= b) begin
      r = a; v = 1'b1; n = 1'b0; z = 1'b0;
    end else begin
      r = {8'(a % 16'(b)), 8'(a / 16'(b))};
      v = 1'b0; n = r[15]; z = (r[7:0] == 8'h00);
    end
    return {r, v, n, z};
  endfunction

  // issue one op; returns number of edges until done (0 if timed out)
  task automatic run_op(input logic op, input logic [15:0] a, input logic [7:0] b,
                        output int lat);
    @(negedge clk);
    op_div_i = op; acc_i = a; opnd_i = b; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    lat = 0;
    check("R7", "busy after start", 32'(busy_o), 32'd1);
    for (int k = 1; k <= 20; k++) begin
      @(negedge clk);
      if (done_o) begin
        lat = k;
        break;
      end
    end
  endtask

  task automatic check_result(input string req, input logic op,
                              input logic [15:0] a, input logic [7:0] b);
    logic [18:0] e;
    e = model(op, a, b);
    check(req, "result", 32'(result_o), 32'(e[18:3]));
    check(op ? (e[2] ? "R6" : "R10") : "R10", "flag V", 32'(flag_v_o), 32'(e[2]));
    check("R10", "flag N", 32'(flag_n_o), 32'(e[1]));
    check("R9", "flag Z", 32'(flag_z_o), 32'(e[0]));
  endtask

  initial begin
    int lat;
    logic [15:0] held;
    n_chk = 0; n_bad = 0;
    start_i = 1'b0; op_div_i = 1'b0; acc_i = '0; opnd_i = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R11: reset state while held
    check("R11", "busy in reset", 32'(busy_o), 32'd0);
    check("R11", "result in reset", 32'(result_o), 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R11", "done after reset", 32'(done_o), 32'd0);
    check("R11", "flags after reset", {29'd0, flag_v_o, flag_n_o, flag_z_o}, 32'd0);

    // table walk: R1, R3, R5, R6, R9, R10, with latency R2/R4
    for (int i = 0; i < NVEC; i++) begin
      logic op;
      op = VEC[i][24];
      run_op(op, VEC[i][23:8], VEC[i][7:0], lat);
      check(op ? "R4" : "R2", "latency", 32'(lat), op ? 32'd9 : 32'd8);
      check(op ? "R3" : "R1", "result/flags", 32'(result_o),
            32'(model(op, VEC[i][23:8], VEC[i][7:0]) >> 3));
      check_result(op ? "R3" : "R1", op, VEC[i][23:8], VEC[i][7:0]);
      check("R7", "busy low at done", 32'(busy_o), 32'd0);
      @(negedge clk);
      check("R7", "done one cycle", 32'(done_o), 32'd0);
    end

    // R5: divide by zero explicit
    run_op(1'b1, 16'h0042, 8'h00, lat);
    check("R5", "div0 V", 32'(flag_v_o), 32'd1);
    check("R5", "div0 result", 32'(result_o), 32'h0042);

    // R12: inputs change without start, outputs hold
    held = result_o;
    @(negedge clk);
    acc_i = 16'h5555; opnd_i = 8'h11; op_div_i = 1'b0;
    repeat (5) @(negedge clk);
    check("R12", "result held", 32'(result_o), 32'(held));
    check("R12", "V held", 32'(flag_v_o), 32'd1);

    // R8: start while busy is ignored
    @(negedge clk);
    op_div_i = 1'b0; acc_i = 16'h0009; opnd_i = 8'h07; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    @(negedge clk);
    op_div_i = 1'b1; acc_i = 16'h0100; opnd_i = 8'h03; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    lat = 0;
    for (int k = 3; k <= 20; k++) begin
      @(negedge clk);
      if (done_o) begin
        lat = k;
        break;
      end
    end
    check("R8", "latency kept", 32'(lat), 32'd8);
    check("R8", "first op result", 32'(result_o), 32'd63);
    begin
      int extra;
      extra = 0;
      for (int k = 0; k < 12; k++) begin
        @(negedge clk);
        if (done_o) extra++;
      end
      check("R8", "no extra completion", 32'(extra), 32'd0);
    end

    // R11: reset in the middle of an operation
    run_op(1'b0, 16'h00FF, 8'hFF, lat);
    @(negedge clk);
    op_div_i = 1'b1; acc_i = 16'h1234; opnd_i = 8'h56; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R11", "busy cleared by reset", 32'(busy_o), 32'd0);
    check("R11", "result cleared by reset", 32'(result_o), 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R11", "no done after reset", 32'(done_o), 32'd0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule